// File: doc/BRIEF.md
# Dual-Channel Serial Wiper Register Interface

This block is the digital control front end of a two-channel programmable resistor. A host writes it over a three-wire serial link made of a select line, a serial clock and a data line. Each frame holds one channel-address bit and eight data bits. When the select line is released, the eight data bits are copied into the wiper code register of the addressed channel. The other channel keeps its code. The two 8-bit wiper codes are the block's main outputs and feed the resistor switch decoders.

The serial register also drives a data output from its far end. Several such blocks can therefore be chained on one select line, with no extra decoding. An active-low preset input and the block reset both put each wiper at midscale. An active-low shutdown request is synchronised and passed on as a status output, and it leaves the codes untouched.

All serial inputs are sampled with the on-chip clock `clk` through a two-stage synchroniser. Serial clock edges and select edges are detected in that clock domain, so the whole block runs on one clock.

Top module: `dual_wiper_if`

## Requirements
- R1: A frame is sent first bit first: the channel-address bit, then data bit 7 down to data bit 0. Each data-line bit is taken into the 9-bit serial register on a rising edge of `ser_clk` while `ser_cs_n` is low. The newest bit enters bit 0 and the oldest bit sits in bit 8.
- R2: On a rising edge of `ser_cs_n`, serial register bits 7..0 are copied into a wiper code. Bit 8 selects the channel: 0 loads `code_ch1` and 1 loads `code_ch2`. The code changes on the third `clk` rising edge after the select line rises.
- R3: A wiper code keeps its value until a frame addressed to its own channel completes. A frame for one channel leaves the other channel's code unchanged.
- R4: On each falling edge of `ser_clk` while `ser_cs_n` is low, `ser_dout` takes serial register bit 8. That bit is the one entered nine rising edges earlier. `ser_dout` holds its value at all other times, including while `ser_cs_n` is high.
- R5: While `preset_n` is low, both codes are 0x80 at once, the serial register and `ser_dout` are cleared, and select rising edges load nothing.
- R6: While `rst_n` is low, both codes are 0x80, `ser_dout` is 0 and `shdn_stat_n` is 1.
- R7: A frame of fewer or more than nine serial clocks still loads from the nine most recently entered bits.
- R8: `shdn_stat_n` follows `shdn_n` two `clk` rising edges later, and shutdown has no effect on either code.
- R9: A rising edge of the select line does not clear the serial register. During the next frame, the first nine bits on `ser_dout` are the previous nine bits entered, which lets chained devices pass data through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to sample the serial link |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_cs_n | input | 1 | Active-low frame select |
| ser_din | input | 1 | Serial data in |
| preset_n | input | 1 | Asynchronous active-low midscale preset |
| shdn_n | input | 1 | Active-low shutdown request |
| ser_dout | output | 1 | Serial data out, taken from the far end of the serial register |
| code_ch1 | output | 8 | Wiper code of channel 1 |
| code_ch2 | output | 8 | Wiper code of channel 2 |
| shdn_stat_n | output | 1 | Synchronised shutdown status, active low |

## Verification
Every serial input passes through two synchroniser flops and one edge flop. Because of this:
- a serial-register shift happens on the third `clk` edge after a `ser_clk` rise;
- a wiper load happens on the third edge after a `ser_cs_n` rise;
- a `ser_dout` update happens on the third edge after a `ser_clk` fall;
- `shdn_stat_n` follows `shdn_n` after two edges;
- preset acts with no clock at all.

The bench holds each serial clock phase for four `clk` periods and sets inputs on falling `clk` edges. It samples `ser_dout` just before the next serial rise, and it samples the codes five falling edges after the select line rises, so every result is sampled after it is due and before the next stimulus.

// File: rtl/wiper_pkg.sv
`timescale 1ns/1ps
package wiper_pkg;
   // one address bit selects between two channels
   localparam int ADDR_W = 1;
   localparam int NCH    = 2 ** ADDR_W;

   // positions of the raw inputs inside the synchroniser bus
   typedef enum int {
      LANE_SCK  = 0,
      LANE_CS   = 1,
      LANE_DIN  = 2,
      LANE_SHDN = 3
   } lane_e;
   localparam int LANES = 4;
endpackage

// File: rtl/wiper_sync_bus.sv
`timescale 1ns/1ps
module wiper_sync_bus #(
   parameter int           W      = 4,
   parameter int           STAGES = 2,
   parameter logic [W-1:0] IDLE   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);
   // pipe[STAGES-1] is the synchronised value, pipe[STAGES] its previous sample
   logic [W-1:0] pipe [0:STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i <= STAGES; i++) pipe[i] <= IDLE;
      end else begin
         pipe[0] <= d;
         for (int i = 1; i <= STAGES; i++) pipe[i] <= pipe[i-1];
      end
   end

   assign q    = pipe[STAGES-1];
   assign rise = pipe[STAGES-1] & ~pipe[STAGES];
   assign fall = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/wiper_frame_shifter.sv
`timescale 1ns/1ps
module wiper_frame_shifter #(
   parameter int FRAME_W = 9
) (
   input  logic               clk,
   input  logic               clr_n,
   input  logic               shift_en,
   input  logic               din,
   input  logic               out_en,
   output logic [FRAME_W-1:0] frame_o,
   output logic               dout_o
);
   logic [FRAME_W-1:0] sr_q;
   logic               dout_q;

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) begin
         sr_q   <= '0;
         dout_q <= 1'b0;
      end else begin
         if (shift_en) sr_q   <= {sr_q[FRAME_W-2:0], din};
         if (out_en)   dout_q <= sr_q[FRAME_W-1];
      end
   end

   assign frame_o = sr_q;
   assign dout_o  = dout_q;
endmodule

// File: rtl/wiper_bank.sv
`timescale 1ns/1ps
module wiper_bank #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 1,
   parameter int NCH    = 2
) (
   input  logic                  clk,
   input  logic                  clr_n,
   input  logic                  load,
   input  logic [ADDR_W-1:0]     sel,
   input  logic [DATA_W-1:0]     data,
   output logic [NCH*DATA_W-1:0] codes_o
);
   localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [DATA_W-1:0] code_q;
      always_ff @(posedge clk or negedge clr_n) begin
         if (!clr_n)                           code_q <= MID;
         else if (load && sel == ADDR_W'(c))   code_q <= data;
      end
      assign codes_o[c*DATA_W +: DATA_W] = code_q;
   end
endmodule

// File: rtl/dual_wiper_if.sv
`timescale 1ns/1ps
module dual_wiper_if #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_cs_n,
   input  logic              ser_din,
   input  logic              preset_n,
   input  logic              shdn_n,
   output logic              ser_dout,
   output logic [DATA_W-1:0] code_ch1,
   output logic [DATA_W-1:0] code_ch2,
   output logic              shdn_stat_n
);
   import wiper_pkg::*;

   localparam int FRAME_W = ADDR_W + DATA_W;
   localparam logic [LANES-1:0] IDLE = 4'b1010;

   if (DATA_W < 2) begin : g_bad_data_w
      $error("dual_wiper_if: DATA_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dual_wiper_if: SYNC_STAGES must be at least 2");
   end

   logic [LANES-1:0]     raw, sync_q, sync_rise, sync_fall;
   logic                 clr_n;
   logic                 cs_rise, sck_fall, shift_en, out_en;
   logic [FRAME_W-1:0]   frame_q;
   logic [NCH*DATA_W-1:0] codes;
   logic                 unused_edges;

   assign raw = {shdn_n, ser_din, ser_cs_n, ser_clk};

   // async clear shared by reset and preset
   assign clr_n = rst_n & preset_n;

   wiper_sync_bus #(.W(LANES), .STAGES(SYNC_STAGES), .IDLE(IDLE)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(raw),
      .q(sync_q), .rise(sync_rise), .fall(sync_fall)
   );

   assign cs_rise  = sync_rise[LANE_CS];
   assign sck_fall = sync_fall[LANE_SCK];
   assign shift_en = sync_rise[LANE_SCK] & ~sync_q[LANE_CS];
   assign out_en   = sck_fall & ~sync_q[LANE_CS];

   assign unused_edges = ^{sync_rise[LANE_DIN], sync_rise[LANE_SHDN],
                           sync_fall[LANE_DIN], sync_fall[LANE_SHDN],
                           sync_fall[LANE_CS], sync_q[LANE_SCK]};

   wiper_frame_shifter #(.FRAME_W(FRAME_W)) i_shift (
      .clk(clk), .clr_n(clr_n), .shift_en(shift_en), .din(sync_q[LANE_DIN]),
      .out_en(out_en), .frame_o(frame_q), .dout_o(ser_dout)
   );

   wiper_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NCH(NCH)) i_bank (
      .clk(clk), .clr_n(clr_n), .load(cs_rise),
      .sel(frame_q[FRAME_W-1 -: ADDR_W]), .data(frame_q[DATA_W-1:0]),
      .codes_o(codes)
   );

   assign code_ch1    = codes[0 +: DATA_W];
   assign code_ch2    = codes[DATA_W +: DATA_W];
   assign shdn_stat_n = sync_q[LANE_SHDN];
endmodule

// File: rtl/dual_wiper_chk.sv
`timescale 1ns/1ps
module dual_wiper_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              preset_n,
   input logic              cs_rise,
   input logic              sck_fall,
   input logic [DATA_W:0]   frame_q,
   input logic [DATA_W-1:0] code_ch1,
   input logic [DATA_W-1:0] code_ch2,
   input logic              ser_dout
);
   localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

   // R2
   load_ch1_chk: assert property (@(posedge clk) disable iff (!rst_n || !preset_n)
      (cs_rise && !frame_q[DATA_W]) |=>
         (code_ch1 == $past(frame_q[DATA_W-1:0])) && $stable(code_ch2));

   // R2
   load_ch2_chk: assert property (@(posedge clk) disable iff (!rst_n || !preset_n)
      (cs_rise && frame_q[DATA_W]) |=>
         (code_ch2 == $past(frame_q[DATA_W-1:0])) && $stable(code_ch1));

   // R3
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !preset_n)
      !cs_rise |=> $stable(code_ch1) && $stable(code_ch2));

   // R5
   preset_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !preset_n |-> (code_ch1 == MID) && (code_ch2 == MID) && !ser_dout);

   // R4
   dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !preset_n)
      !sck_fall |=> $stable(ser_dout));
endmodule

bind dual_wiper_if dual_wiper_chk #(.DATA_W(DATA_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .preset_n(preset_n), .cs_rise(cs_rise),
   .sck_fall(sck_fall), .frame_q(frame_q), .code_ch1(code_ch1),
   .code_ch2(code_ch2), .ser_dout(ser_dout)
);

// File: tb/test_dual_wiper_if.sv
`timescale 1ns/1ps
module test_dual_wiper_if;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n = 1'b0, ser_clk = 1'b0, ser_cs_n = 1'b1, ser_din = 1'b0;
   logic preset_n = 1'b1, shdn_n = 1'b1;
   logic ser_dout, shdn_stat_n;
   logic [7:0] code_ch1, code_ch2;

   dual_wiper_if i_dual_wiper_if (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_cs_n(ser_cs_n),
      .ser_din(ser_din), .preset_n(preset_n), .shdn_n(shdn_n),
      .ser_dout(ser_dout), .code_ch1(code_ch1), .code_ch2(code_ch2),
      .shdn_stat_n(shdn_stat_n)
   );

   // sel: 0 = code_ch1, 1 = code_ch2, 2 = ser_dout, 3 = shdn_stat_n
   typedef struct {
      string      req;
      int         sel;
      logic [7:0] exp;
   } item_t;

   item_t sb[$];
   event  sb_ev;
   int    checks = 0, errors = 0;
   bit    done = 0;

   // expected state derived from the requirements
   logic [8:0] model = '0;
   logic [7:0] m1 = 8'h80, m2 = 8'h80;
   logic       msdo = 1'b0;
   bit         preset_on = 0;

   task automatic push(string r, int s, logic [7:0] e);
      item_t it;
      it.req = r; it.sel = s; it.exp = e;
      sb.push_back(it);
      ->sb_ev;
   endtask

   initial begin
      forever begin
         @(sb_ev);
         while (sb.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb.pop_front();
            case (it.sel)
               0:       act = code_ch1;
               1:       act = code_ch2;
               2:       act = {7'b0, ser_dout};
               default: act = {7'b0, shdn_stat_n};
            endcase
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s output %0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
            end
         end
      end
   end

   task automatic wait_clk(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ser_fall();
      if (ser_clk && !preset_on) msdo = model[8];
      ser_clk = 1'b0;
   endtask

   task automatic send_bit(logic b, string dreq);
      ser_fall();
      ser_din = b;
      wait_clk(4);
      push(dreq, 2, {7'b0, msdo});
      ser_clk = 1'b1;
      if (!preset_on) model = {model[7:0], b};
      wait_clk(4);
   endtask

   task automatic send_frame(logic [15:0] v, int n, string req, string dreq);
      ser_cs_n = 1'b0;
      wait_clk(4);
      for (int i = n - 1; i >= 0; i--) send_bit(v[i], dreq);
      ser_fall();
      wait_clk(4);
      ser_cs_n = 1'b1;
      if (!preset_on) begin
         if (model[8]) m2 = model[7:0];
         else          m1 = model[7:0];
      end
      wait_clk(5);
      push(req, 0, m1);
      push(req, 1, m2);
      push(dreq, 2, {7'b0, msdo});
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         finish_run();
      end
   end

   initial begin
      wait_clk(5);
      // R6 reset state
      push("R6", 0, 8'h80);
      push("R6", 1, 8'h80);
      push("R6", 2, 8'h00);
      push("R6", 3, 8'h01);
      rst_n = 1'b1;
      wait_clk(3);

      // R1 R2 basic loads to each channel
      send_frame(16'h003C, 9, "R1 R2", "R4");
      send_frame(16'h01A5, 9, "R2 R3", "R4");
      send_frame(16'h00FF, 9, "R3", "R4");
      send_frame(16'h0100, 9, "R1 R3", "R4");
      // R9 chained data passes through the register
      send_frame(16'h0155, 9, "R2", "R9");
      // R7 short and long frames
      send_frame(16'h0016, 5, "R7", "R4");
      send_frame(16'h0ABC, 12, "R7", "R9");
      send_frame(16'h0003, 2, "R7", "R4");

      // R8 shutdown passes through, codes kept
      shdn_n = 1'b0;
      wait_clk(3);
      push("R8", 3, 8'h00);
      push("R8", 0, m1);
      push("R8", 1, m2);
      send_frame(16'h00C3, 9, "R8", "R4");
      shdn_n = 1'b1;
      wait_clk(3);
      push("R8", 3, 8'h01);

      // R5 preset forces midscale and blocks loads
      preset_n = 1'b0;
      preset_on = 1;
      model = '0; msdo = 1'b0; m1 = 8'h80; m2 = 8'h80;
      wait_clk(1);
      push("R5", 0, 8'h80);
      push("R5", 1, 8'h80);
      push("R5", 2, 8'h00);
      send_frame(16'h0111, 9, "R5", "R5");
      preset_n = 1'b1;
      preset_on = 0;
      wait_clk(3);
      send_frame(16'h0042, 9, "R5 R2", "R5 R9");
      send_frame(16'h0199, 9, "R2", "R9");

      done = 1;
      wait_clk(2);
      finish_run();
   end
endmodule